// File: doc/BRIEF.md
# Memory Protection Region Attribute Matcher

This block keeps a set of programmable address regions and, for every address presented on its lookup port, returns the memory attributes and access permissions that apply to it, together with a fault flag when the requested access kind is not allowed there. Each region has an enable, a base address, a size exponent, three permission bits (read, write, fetch) and the cache attribute bits: a 3-bit type-extension field, cacheable, bufferable and shareable. Software or a configuration sequencer fills the regions through a single-cycle write port, one region per write.

A region is always naturally aligned. Its size is a power of two, and only the address bits above the size are compared, so a base that is not aligned is cropped to the aligned block that contains it. Enabled regions may overlap, and the highest-numbered matching region wins, which lets a small window inside a larger region carry its own attributes. An address that no enabled region covers takes its attributes from a fixed default map keyed on the top three address bits. The result is registered, so it appears one cycle after the lookup request.

The lookup path has two phases. A combinational phase compares the address against every region, picks the winner and applies the default map on a miss. A registered phase holds the result for one cycle. There is no other sequencing.

Top module: `mpr_matcher`

## Requirements
- R1: After reset every region is disabled and `res_valid` is 0. A lookup made before any configuration write reports `res_hit`=0 and the default attributes.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1. The result fields in that cycle belong to the address and kind presented with that request.
- R3: A region with size field `s` covers 2^(s+1) bytes. Field values below 4 are treated as 4, so the smallest region is 32 bytes. Field value 31 covers the whole 32-bit space.
- R4: Only address bits at and above position s+1 (with s clamped as in R3) are compared. The base bits below that position are ignored, so a misaligned base selects the aligned block that contains it.
- R5: When several enabled regions match, the result comes from the highest-numbered one.
- R6: A disabled region never matches, whatever its other fields hold.
- R7: With no match, `res_hit`=0, `res_region`=0 and the attributes come from the top three address bits. Each entry is written as perm (bit0 read, bit1 write, bit2 fetch), tex, C, B, S:
  - 0: 111, 000, 1, 0, 0
  - 1: 111, 001, 1, 1, 0
  - 2: 011, 000, 0, 1, 1
  - 3: 111, 001, 1, 1, 0
  - 4: 111, 000, 1, 0, 0
  - 5 and 6: 011, 000, 0, 1, 1
  - 7: 011, 000, 0, 0, 1
- R8: `lk_kind` encodes 0 read, 1 write, 2 fetch, and 3 is treated as read. `res_fault` is 1 exactly when the effective permission bit for that kind (read bit0, write bit1, fetch bit2) is 0.
- R9: A write with `cfg_we`=1 replaces all fields of region `cfg_idx`. It applies to lookups issued from the next cycle on and leaves every other region unchanged.
- R10: On a match, `res_hit`=1, `res_region` is the winning index, and `res_perm`, `res_tex`, `res_cache`, `res_buf` and `res_share` are that region's programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 4 | Region index to write |
| cfg_enable | input | 1 | Enable value for the region |
| cfg_base | input | 32 | Base address |
| cfg_size | input | 5 | Size exponent field |
| cfg_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 fetch |
| cfg_tex | input | 3 | Type-extension attribute |
| cfg_cache | input | 1 | Cacheable attribute |
| cfg_buf | input | 1 | Bufferable attribute |
| cfg_share | input | 1 | Shareable attribute |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | A region matched |
| res_region | output | 4 | Winning region index, 0 on a miss |
| res_perm | output | 3 | Effective permissions |
| res_tex | output | 3 | Effective type-extension attribute |
| res_cache | output | 1 | Effective cacheable bit |
| res_buf | output | 1 | Effective bufferable bit |
| res_share | output | 1 | Effective shareable bit |
| res_fault | output | 1 | Requested access kind not permitted |

## Verification
The bench builds the block with its default parameters: sixteen regions, a 32-bit address and a 5-bit size field. With sixteen regions, the top index can win a priority contest over regions below it, and a full region file can be overlapped at once. With the 5-bit field, the bench can reach both the clamped 32-byte minimum and the value that spans the entire address space. This lets the bench cover the cropping of misaligned bases at both ends of the size range.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef struct packed {
        logic [2:0] perm;   // bit0 read, bit1 write, bit2 fetch
        logic [2:0] tex;
        logic       cache;
        logic       bufr;
        logic       share;
    } mpr_attr_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } mpr_kind_e;

    typedef enum logic [2:0] {
        SEG_CODE   = 3'd0,
        SEG_SRAM   = 3'd1,
        SEG_PERIPH = 3'd2,
        SEG_XRAM_A = 3'd3,
        SEG_XRAM_B = 3'd4,
        SEG_XDEV_A = 3'd5,
        SEG_XDEV_B = 3'd6,
        SEG_SYSTEM = 3'd7
    } mpr_seg_e;

    localparam int MIN_EXP = 4;

    function automatic logic kind_allowed(input logic [2:0] perm, input logic [1:0] kind);
        unique case (mpr_kind_e'(kind))
            ACC_WRITE: return perm[1];
            ACC_FETCH: return perm[2];
            default:   return perm[0];
        endcase
    endfunction

endpackage

// File: rtl/mpr_region_file.sv
module mpr_region_file
    import mpr_pkg::*;
#(
    parameter int N_REGIONS = 16,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 5,
    parameter int IDX_W     = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic                             wr_enable,
    input  logic [ADDR_W-1:0]                wr_base,
    input  logic [SIZE_W-1:0]                wr_size,
    input  mpr_attr_t                        wr_attr,
    output logic [N_REGIONS-1:0]             reg_en,
    output logic [N_REGIONS-1:0][ADDR_W-1:0] reg_base,
    output logic [N_REGIONS-1:0][SIZE_W-1:0] reg_size,
    output mpr_attr_t [N_REGIONS-1:0]        reg_attr
);

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_en[g]   <= 1'b0;
                reg_base[g] <= '0;
                reg_size[g] <= '0;
                reg_attr[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                reg_en[g]   <= wr_enable;
                reg_base[g] <= wr_base;
                reg_size[g] <= wr_size;
                reg_attr[g] <= wr_attr;
            end
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reg_en[$past(wr_idx)] == $past(wr_enable))
               && (reg_base[$past(wr_idx)] == $past(wr_base))
               && (reg_attr[$past(wr_idx)] == $past(wr_attr))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_en) && $stable(reg_base) && $stable(reg_size)); // R9

endmodule

// File: rtl/mpr_hit_vector.sv
module mpr_hit_vector
    import mpr_pkg::*;
#(
    parameter int N_REGIONS = 16,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 5
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [N_REGIONS-1:0]             reg_en,
    input  logic [N_REGIONS-1:0][ADDR_W-1:0] reg_base,
    input  logic [N_REGIONS-1:0][SIZE_W-1:0] reg_size,
    output logic [N_REGIONS-1:0]             hits
);

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_cmp
        logic [ADDR_W-1:0] keep_mask;
        int                low_bits;

        always_comb begin
            low_bits = ((int'(reg_size[g]) < MIN_EXP) ? MIN_EXP : int'(reg_size[g])) + 1;
            for (int j = 0; j < ADDR_W; j++) begin
                keep_mask[j] = (j >= low_bits);
            end
            hits[g] = reg_en[g] && (((addr ^ reg_base[g]) & keep_mask) == '0);
        end
    end

endmodule

// File: rtl/mpr_prio_select.sv
module mpr_prio_select #(
    parameter int N_REGIONS = 16,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_REGIONS-1:0] hits,
    output logic                 any_hit,
    output logic [IDX_W-1:0]     win_idx
);

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (hits[i]) win_idx = IDX_W'(i);
        end
        any_hit = |hits;
    end

    AST_WINNER_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hits >> win_idx) == N_REGIONS'(1))); // R5

    AST_NO_HIT_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (win_idx == '0)); // R7

endmodule

// File: rtl/mpr_default_map.sv
module mpr_default_map
    import mpr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output mpr_attr_t         dflt
);

    mpr_seg_e seg;

    always_comb begin
        seg = mpr_seg_e'(addr[ADDR_W-1 -: 3]);
        unique case (seg)
            SEG_CODE, SEG_XRAM_B: dflt = '{perm: 3'b111, tex: 3'b000, cache: 1'b1, bufr: 1'b0, share: 1'b0};
            SEG_SRAM, SEG_XRAM_A: dflt = '{perm: 3'b111, tex: 3'b001, cache: 1'b1, bufr: 1'b1, share: 1'b0};
            SEG_PERIPH, SEG_XDEV_A, SEG_XDEV_B:
                                  dflt = '{perm: 3'b011, tex: 3'b000, cache: 1'b0, bufr: 1'b1, share: 1'b1};
            default:              dflt = '{perm: 3'b011, tex: 3'b000, cache: 1'b0, bufr: 1'b0, share: 1'b1};
        endcase
    end

endmodule

// File: rtl/mpr_matcher.sv
module mpr_matcher
    import mpr_pkg::*;
#(
    parameter  int N_REGIONS = 16,
    parameter  int ADDR_W    = 32,
    parameter  int SIZE_W    = 5,
    localparam int IDX_W     = $clog2(N_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [2:0]        cfg_perm,
    input  logic [2:0]        cfg_tex,
    input  logic              cfg_cache,
    input  logic              cfg_buf,
    input  logic              cfg_share,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [1:0]        lk_kind,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_region,
    output logic [2:0]        res_perm,
    output logic [2:0]        res_tex,
    output logic              res_cache,
    output logic              res_buf,
    output logic              res_share,
    output logic              res_fault
);

    logic [N_REGIONS-1:0]             reg_en;
    logic [N_REGIONS-1:0][ADDR_W-1:0] reg_base;
    logic [N_REGIONS-1:0][SIZE_W-1:0] reg_size;
    mpr_attr_t [N_REGIONS-1:0]        reg_attr;
    logic [N_REGIONS-1:0]             hits;
    logic                             any_hit;
    logic [IDX_W-1:0]                 win_idx;
    mpr_attr_t                        dflt_attr;
    mpr_attr_t                        eff_attr;
    mpr_attr_t                        wr_attr;
    logic                             eff_fault;

    assign wr_attr = '{perm: cfg_perm, tex: cfg_tex, cache: cfg_cache, bufr: cfg_buf, share: cfg_share};

    mpr_region_file #(
        .N_REGIONS(N_REGIONS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)
    ) u_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_enable(cfg_enable),
        .wr_base(cfg_base), .wr_size(cfg_size), .wr_attr(wr_attr),
        .reg_en(reg_en), .reg_base(reg_base), .reg_size(reg_size), .reg_attr(reg_attr)
    );

    mpr_hit_vector #(
        .N_REGIONS(N_REGIONS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
    ) u_hits (
        .addr(lk_addr), .reg_en(reg_en), .reg_base(reg_base), .reg_size(reg_size), .hits(hits)
    );

    mpr_prio_select #(
        .N_REGIONS(N_REGIONS), .IDX_W(IDX_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n), .hits(hits), .any_hit(any_hit), .win_idx(win_idx)
    );

    mpr_default_map #(
        .ADDR_W(ADDR_W)
    ) u_dflt (
        .addr(lk_addr), .dflt(dflt_attr)
    );

    always_comb begin
        eff_attr  = any_hit ? reg_attr[win_idx] : dflt_attr;
        eff_fault = !kind_allowed(eff_attr.perm, lk_kind);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
        end else begin
            res_valid <= lk_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hit    <= 1'b0;
            res_region <= '0;
            res_perm   <= '0;
            res_tex    <= '0;
            res_cache  <= 1'b0;
            res_buf    <= 1'b0;
            res_share  <= 1'b0;
            res_fault  <= 1'b0;
        end else if (lk_valid) begin
            res_hit    <= any_hit;
            res_region <= win_idx;
            res_perm   <= eff_attr.perm;
            res_tex    <= eff_attr.tex;
            res_cache  <= eff_attr.cache;
            res_buf    <= eff_attr.bufr;
            res_share  <= eff_attr.share;
            res_fault  <= eff_fault;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R2

    AST_FAULT_NEEDS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_perm != 3'b111)); // R8

    AST_MISS_REGION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_region == '0)); // R7

    AST_HIT_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && any_hit) |-> reg_en[win_idx]); // R6

endmodule

// File: tb/sim_mpr_matcher.sv
module sim_mpr_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic [2:0]  cfg_perm = '0;
    logic [2:0]  cfg_tex = '0;
    logic        cfg_cache = 1'b0;
    logic        cfg_buf = 1'b0;
    logic        cfg_share = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_kind = '0;
    logic        res_valid, res_hit, res_cache, res_buf, res_share, res_fault;
    logic [3:0]  res_region;
    logic [2:0]  res_perm, res_tex;

    int checks = 0;
    int errors = 0;

    logic        m_en   [16];
    logic [31:0] m_base [16];
    logic [4:0]  m_size [16];
    logic [8:0]  m_attr [16];   // {perm, tex, c, b, s}

    always #2 clk = ~clk;

    mpr_matcher u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_perm(cfg_perm), .cfg_tex(cfg_tex), .cfg_cache(cfg_cache),
        .cfg_buf(cfg_buf), .cfg_share(cfg_share),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(lk_kind),
        .res_valid(res_valid), .res_hit(res_hit), .res_region(res_region), .res_perm(res_perm),
        .res_tex(res_tex), .res_cache(res_cache), .res_buf(res_buf), .res_share(res_share),
        .res_fault(res_fault)
    );

    function automatic logic [8:0] dflt_of(input logic [31:0] a);
        case (a[31:29])
            3'd0, 3'd4: return {3'b111, 3'b000, 1'b1, 1'b0, 1'b0};
            3'd1, 3'd3: return {3'b111, 3'b001, 1'b1, 1'b1, 1'b0};
            3'd2, 3'd5, 3'd6: return {3'b011, 3'b000, 1'b0, 1'b1, 1'b1};
            default: return {3'b011, 3'b000, 1'b0, 1'b0, 1'b1};
        endcase
    endfunction

    // {hit, region[3:0], perm[2:0], tex[2:0], c, b, s, fault}
    function automatic logic [14:0] expect_of(input logic [31:0] a, input logic [1:0] kind);
        logic        hit = 1'b0;
        logic [3:0]  reg_i = '0;
        logic [8:0]  at;
        logic        ok;
        at = dflt_of(a);
        for (int i = 15; i >= 0; i--) begin
            int e;
            logic [63:0] diff;
            e = (m_size[i] < 5'd4) ? 4 : int'(m_size[i]);
            diff = {32'b0, a ^ m_base[i]} >> (e + 1);
            if (!hit && m_en[i] && diff == 64'd0) begin
                hit = 1'b1;
                reg_i = 4'(i);
                at = m_attr[i];
            end
        end
        case (kind)
            2'd1: ok = at[7];
            2'd2: ok = at[8];
            default: ok = at[6];
        endcase
        return {hit, reg_i, at, !ok};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic write_region(input int idx, input logic en, input logic [31:0] base,
                                input logic [4:0] sz, input logic [8:0] attr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_enable = en; cfg_base = base; cfg_size = sz;
        {cfg_perm, cfg_tex, cfg_cache, cfg_buf, cfg_share} = attr;
        m_en[idx] = en; m_base[idx] = base; m_size[idx] = sz; m_attr[idx] = attr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic [1:0] kind);
        logic [14:0] exp;
        logic [14:0] got;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_kind = kind;
        exp = expect_of(a, kind);
        @(negedge clk);
        got = {res_hit, res_region, res_perm, res_tex, res_cache, res_buf, res_share, res_fault};
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check(req, 32'(got), 32'(exp));
        lk_valid = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_tap;
        seed_tap = $urandom(32'h5EED);
        for (int i = 0; i < 16; i++) begin
            m_en[i] = 1'b0; m_base[i] = '0; m_size[i] = '0; m_attr[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 32'(res_valid), 32'd0);
        lookup("R1 R7 sram default", 32'h2000_0100, 2'd1);
        lookup("R7 periph fetch fault", 32'h4000_0000, 2'd2);
        lookup("R7 system", 32'hE000_ED00, 2'd0);
        lookup("R7 xram_b", 32'h8123_4567, 2'd2);
        @(negedge clk);
        check("R2 valid drops", 32'(res_valid), 32'd0);

        // misaligned 64 KB region, cropped
        write_region(3, 1'b1, 32'h6000_1234, 5'd15, {3'b111, 3'b010, 1'b0, 1'b0, 1'b1});
        lookup("R4 crop low edge", 32'h6000_0000, 2'd0);
        lookup("R4 crop high edge", 32'h6000_FFFC, 2'd1);
        lookup("R3 R4 outside", 32'h6001_0000, 2'd0);
        // clamped minimum size
        write_region(5, 1'b1, 32'h1000_0047, 5'd0, {3'b001, 3'b100, 1'b1, 1'b0, 1'b0});
        lookup("R3 min size in", 32'h1000_005F, 2'd0);
        lookup("R3 min size out", 32'h1000_0060, 2'd0);
        lookup("R8 write to ro", 32'h1000_0040, 2'd1);
        lookup("R8 fetch to ro", 32'h1000_0040, 2'd2);
        lookup("R8 kind3 as read", 32'h1000_0040, 2'd3);
        // overlap priority
        write_region(1, 1'b1, 32'h6000_0000, 5'd19, {3'b011, 3'b000, 1'b1, 1'b1, 1'b0});
        write_region(9, 1'b1, 32'h6004_0000, 5'd11, {3'b101, 3'b001, 1'b0, 1'b1, 1'b1});
        lookup("R5 R10 inner wins", 32'h6004_0010, 2'd2);
        lookup("R5 outer", 32'h6008_0000, 2'd2);
        write_region(9, 1'b0, 32'h6004_0000, 5'd11, {3'b101, 3'b001, 1'b0, 1'b1, 1'b1});
        lookup("R6 disabled skipped", 32'h6004_0010, 2'd0);
        lookup("R9 others unchanged", 32'h6000_0004, 2'd0);
        // whole-space region at top priority
        write_region(15, 1'b1, 32'hABCD_0000, 5'd31, {3'b110, 3'b111, 1'b1, 1'b1, 1'b1});
        lookup("R3 R5 full space", 32'h0000_0000, 2'd0);
        lookup("R3 R5 full space top", 32'hFFFF_FFFF, 2'd1);
        write_region(15, 1'b0, 32'h0, 5'd0, 9'd0);

        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [4:0] sz;
                sz = ($urandom_range(0, 15) == 0) ? 5'd31 : 5'($urandom_range(0, 20));
                write_region(int'($urandom_range(0, 15)), ($urandom_range(0, 4) != 0),
                             32'h6000_0000 | ($urandom & 32'h001F_FFFF), sz, 9'($urandom));
            end else begin
                logic [31:0] a;
                a = ($urandom_range(0, 1) == 0) ? (32'h6000_0000 | ($urandom & 32'h001F_FFFF)) : $urandom;
                lookup("R10 random", a, 2'($urandom));
            end
        end

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule